// File: doc/BRIEF.md
# Programmable Round, Window and Limit Output Stage

This stage converts a 32-bit signed accumulator result into a 16-bit signed sample. It holds sixteen programmable profiles. A 4-bit select input picks one profile on every clock, so neighbouring samples can be formatted in different ways. Each profile sets which 16-bit window of the accumulator word reaches the output, whether the value is rounded at the bit just below that window, and a pair of signed clamp bounds.

Each sample passes through two register stages. The first stage looks up the profile and adds the rounding increment. The second stage shifts the value, saturates it to the 16-bit range and clamps it to the profile bounds. A valid flag moves along with the data. Software writes a whole profile in one cycle through an address, data and write-enable port.

Top module: `rsl_stage`

## Requirements
- R1: Sixteen profiles exist. `sel_i` equal to n makes the sample taken at that clock edge use profile n, and the selection may change on every cycle.
- R2: When `cfg_we_i` is high at a rising edge, the profile at `cfg_addr_i` takes the window, round, upper and lower values on the cfg inputs. Samples taken at later edges use the new contents. When `cfg_we_i` is low, no profile changes.
- R3: For a window value n from 0 to 16, the output is bits [15+n:n] of the (rounded) input, shifted arithmetically so negative values round toward minus infinity. A stored window value above 16 acts as 16.
- R4: With rounding on and n > 0, 2^(n-1) is added to the input before the window is taken. With n = 0, or with rounding off, nothing is added. The addition is done with one extra bit, so it never wraps.
- R5: If the windowed value lies outside -32768..32767, the output saturates to -32768 or 32767.
- R6: After saturation, a value above the profile's signed upper bound becomes that bound, and a value below the signed lower bound becomes that bound.
- R7: Asynchronous active-low reset sets every profile to window 0, rounding off, upper bound 32767 and lower bound -32768. It also clears `valid_o` and `dout_o` to 0.
- R8: A sample taken at edge k appears on `dout_o` after edge k+1. `valid_o` is high in exactly the cycles that follow the edge k+1 of a sample that was valid.
- R9: In a cycle where `valid_o` is low, `dout_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Profile write strobe |
| cfg_addr_i | input | 4 | Profile index to write |
| cfg_win_i | input | 5 | Window position n |
| cfg_rnd_i | input | 1 | Rounding enable |
| cfg_hi_i | input | 16 | Signed upper clamp bound |
| cfg_lo_i | input | 16 | Signed lower clamp bound |
| in_valid_i | input | 1 | Sample valid |
| acc_i | input | 32 | Signed accumulator sample |
| sel_i | input | 4 | Profile select for this sample |
| valid_o | output | 1 | Output valid |
| dout_o | output | 16 | Signed formatted output |

## Verification
The clamp property assumes that every profile in use has an upper bound no lower than its lower bound. The stage does not define an ordering for crossed bounds, so the property only checks samples whose staged bounds are ordered. The bench writes only ordered pairs. The latency property assumes `in_valid_i` is held low while reset is asserted, and the bench does so. Profile writes are kept at least one cycle before the samples that rely on them, because a write and a sample at the same edge see the old contents.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  parameter int OUT_W = 16;
  parameter int WIN_W = 5;

  typedef struct packed {
    logic [WIN_W-1:0]        win;
    logic                    rnd;
    logic signed [OUT_W-1:0] hi;
    logic signed [OUT_W-1:0] lo;
  } prof_t;

  function automatic prof_t prof_rst();
    prof_t p;
    p.win = '0;
    p.rnd = 1'b0;
    p.hi  = {1'b0, {(OUT_W-1){1'b1}}};
    p.lo  = {1'b1, {(OUT_W-1){1'b0}}};
    return p;
  endfunction
endpackage

// File: rtl/rsl_prof_bank.sv
module rsl_prof_bank
  import rsl_pkg::*;
#(
  parameter int NPROF = 16,
  localparam int AW = $clog2(NPROF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  prof_t         wdata_i,
  input  logic [AW-1:0] rsel_i,
  output prof_t         rdata_o,
  output prof_t         tab_o [NPROF]
);
  prof_t tab_q [NPROF];

  for (genvar g = 0; g < NPROF; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          tab_q[g] <= prof_rst();
      else if (we_i && waddr_i == AW'(g))   tab_q[g] <= wdata_i;
    end
  end

  assign rdata_o = tab_q[rsel_i];
  assign tab_o   = tab_q;
endmodule

// File: rtl/rsl_round.sv
module rsl_round
  import rsl_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [ACC_W-1:0] acc_i,
  input  prof_t                   prof_i,
  output logic                    valid_o,
  output logic signed [ACC_W:0]   sum_o,
  output logic [WIN_W-1:0]        sh_o,
  output logic signed [OUT_W-1:0] hi_o,
  output logic signed [OUT_W-1:0] lo_o
);
  localparam logic [WIN_W-1:0] MAX_SH = WIN_W'(ACC_W - OUT_W);

  logic [WIN_W-1:0]      sh;
  logic signed [ACC_W:0] ext, inc;

  always_comb begin
    sh  = (prof_i.win > MAX_SH) ? MAX_SH : prof_i.win;
    ext = {acc_i[ACC_W-1], acc_i};
    // half-LSB of the chosen window
    inc = (prof_i.rnd && sh != '0) ? ((ACC_W+1)'(1) << (sh - 1'b1)) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      sh_o    <= '0;
      hi_o    <= '0;
      lo_o    <= '0;
    end else begin
      valid_o <= valid_i;
      sum_o   <= ext + inc;
      sh_o    <= sh;
      hi_o    <= prof_i.hi;
      lo_o    <= prof_i.lo;
    end
  end
endmodule

// File: rtl/rsl_limit.sv
module rsl_limit
  import rsl_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [ACC_W:0]   sum_i,
  input  logic [WIN_W-1:0]        sh_i,
  input  logic signed [OUT_W-1:0] hi_i,
  input  logic signed [OUT_W-1:0] lo_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] dout_o
);
  localparam logic signed [ACC_W:0] POS_LIM = (ACC_W+1)'((64'sd1 <<< (OUT_W-1)) - 1);
  localparam logic signed [ACC_W:0] NEG_LIM = -POS_LIM - 1;

  logic signed [ACC_W:0]   shf;
  logic signed [OUT_W-1:0] sat, res;

  always_comb begin
    shf = sum_i >>> sh_i;
    if (shf > POS_LIM)      sat = POS_LIM[OUT_W-1:0];
    else if (shf < NEG_LIM) sat = NEG_LIM[OUT_W-1:0];
    else                    sat = shf[OUT_W-1:0];
    if (sat > hi_i)         res = hi_i;
    else if (sat < lo_i)    res = lo_i;
    else                    res = sat;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dout_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) dout_o <= res;
    end
  end
endmodule

// File: rtl/rsl_stage.sv
module rsl_stage
  import rsl_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int NPROF = 16,
  localparam int AW = $clog2(NPROF)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [AW-1:0]           cfg_addr_i,
  input  logic [WIN_W-1:0]        cfg_win_i,
  input  logic                    cfg_rnd_i,
  input  logic [OUT_W-1:0]        cfg_hi_i,
  input  logic [OUT_W-1:0]        cfg_lo_i,
  input  logic                    in_valid_i,
  input  logic [ACC_W-1:0]        acc_i,
  input  logic [AW-1:0]           sel_i,
  output logic                    valid_o,
  output logic [OUT_W-1:0]        dout_o
);
  prof_t                   wdata, prof_rd;
  prof_t                   prof_tab [NPROF];
  logic                    s1_valid;
  logic signed [ACC_W:0]   s1_sum;
  logic [WIN_W-1:0]        s1_sh;
  logic signed [OUT_W-1:0] lim_hi_q, lim_lo_q, dout_s;

  assign wdata = '{win: cfg_win_i, rnd: cfg_rnd_i, hi: cfg_hi_i, lo: cfg_lo_i};

  rsl_prof_bank #(.NPROF(NPROF)) u_bank (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .waddr_i(cfg_addr_i), .wdata_i(wdata),
    .rsel_i(sel_i), .rdata_o(prof_rd), .tab_o(prof_tab)
  );

  rsl_round #(.ACC_W(ACC_W)) u_round (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i), .acc_i(acc_i), .prof_i(prof_rd),
    .valid_o(s1_valid), .sum_o(s1_sum), .sh_o(s1_sh),
    .hi_o(lim_hi_q), .lo_o(lim_lo_q)
  );

  rsl_limit #(.ACC_W(ACC_W)) u_limit (
    .clk_i, .rst_ni,
    .valid_i(s1_valid), .sum_i(s1_sum), .sh_i(s1_sh),
    .hi_i(lim_hi_q), .lo_i(lim_lo_q),
    .valid_o(valid_o), .dout_o(dout_s)
  );

  assign dout_o = dout_s;
endmodule

// File: rtl/rsl_stage_chk.sv
module rsl_stage_chk
  import rsl_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int NPROF = 16,
  localparam int AW = $clog2(NPROF)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cfg_we_i,
  input logic [AW-1:0]           cfg_addr_i,
  input logic [WIN_W-1:0]        cfg_win_i,
  input logic                    cfg_rnd_i,
  input logic [OUT_W-1:0]        cfg_hi_i,
  input logic [OUT_W-1:0]        cfg_lo_i,
  input logic                    in_valid_i,
  input logic                    valid_o,
  input logic signed [OUT_W-1:0] dout_o,
  input logic signed [OUT_W-1:0] hi_q,
  input logic signed [OUT_W-1:0] lo_q,
  input prof_t                   tab [NPROF]
);
  p_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (tab[$past(cfg_addr_i)].win == $past(cfg_win_i)) &&
                 (tab[$past(cfg_addr_i)].rnd == $past(cfg_rnd_i)) &&
                 (tab[$past(cfg_addr_i)].hi  == $past(cfg_hi_i)) &&
                 (tab[$past(cfg_addr_i)].lo  == $past(cfg_lo_i)));

  p_clamp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(hi_q) >= $past(lo_q))) |->
      (dout_o <= $past(hi_q)) && (dout_o >= $past(lo_q)));

  p_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(in_valid_i, 2));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(dout_o));
endmodule

bind rsl_stage rsl_stage_chk #(.ACC_W(ACC_W), .NPROF(NPROF)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_win_i(cfg_win_i),
  .cfg_rnd_i(cfg_rnd_i), .cfg_hi_i(cfg_hi_i), .cfg_lo_i(cfg_lo_i),
  .in_valid_i(in_valid_i), .valid_o(valid_o), .dout_o(dout_o),
  .hi_q(lim_hi_q), .lo_q(lim_lo_q), .tab(prof_tab)
);

// File: tb/rsl_stage_tb.sv
module rsl_stage_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 14;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_rnd_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0, sel_i = '0;
  logic [4:0]  cfg_win_i = '0;
  logic [15:0] cfg_hi_i = '0, cfg_lo_i = '0;
  logic        in_valid_i = 1'b0;
  logic [31:0] acc_i = '0;
  logic        valid_o;
  logic [15:0] dout_o;

  int total = 0, bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  rsl_stage u_dut (.*);

  // {sel, acc, expected}
  localparam logic [51:0] VEC [NV] = '{
    {4'd0, 32'h0000_04D2, 16'h04D2},  // R3 R7 default window 0
    {4'd0, 32'h0000_9C40, 16'h7FFF},  // R5 R7 positive saturate
    {4'd0, 32'hFFFF_63C0, 16'h8000},  // R5 negative saturate
    {4'd1, 32'h0000_1280, 16'h0013},  // R4 round up
    {4'd2, 32'h0000_1280, 16'h0012},  // R4 no round
    {4'd1, 32'hFFFF_FE80, 16'hFFFF},  // R4 negative round
    {4'd2, 32'hFFFF_FE80, 16'hFFFE},  // R3 floor on negative
    {4'd3, 32'h1234_8000, 16'h1235},  // R4 window 16
    {4'd3, 32'h7FFF_8000, 16'h7FFF},  // R5 round carries past range
    {4'd4, 32'h0000_0640, 16'h0064},  // R1 within limits
    {4'd4, 32'h0000_4E20, 16'h03E8},  // R6 upper clamp
    {4'd4, 32'hFFFF_B1E0, 16'hFC18},  // R6 lower clamp
    {4'd5, 32'h0005_0000, 16'h0005},  // R3 window above 16 acts as 16
    {4'd5, 32'hFFFD_0000, 16'hFFFD}   // R3
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [4:0] w, input logic r,
                    input logic [15:0] h, input logic [15:0] l, input logic we);
    @(negedge clk_i);
    cfg_we_i = we; cfg_addr_i = a; cfg_win_i = w; cfg_rnd_i = r;
    cfg_hi_i = h; cfg_lo_i = l;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] last;
    #(CLK_P * 3);
    chk("R7 reset dout", dout_o, 16'h0000);
    chk("R7 reset valid", {15'd0, valid_o}, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    wr(4'd1, 5'd8,  1'b1, 16'h7FFF, 16'h8000, 1'b1);
    wr(4'd2, 5'd8,  1'b0, 16'h7FFF, 16'h8000, 1'b1);
    wr(4'd3, 5'd16, 1'b1, 16'h7FFF, 16'h8000, 1'b1);
    wr(4'd4, 5'd4,  1'b1, 16'd1000, 16'hFC18, 1'b1);
    wr(4'd5, 5'd31, 1'b0, 16'h7FFF, 16'h8000, 1'b1);

    // back-to-back walk, profile changes every cycle (R1, R8)
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        chk($sformatf("R8 valid vec %0d", i-2), {15'd0, valid_o}, 16'h0001);
        chk($sformatf("R1 vec %0d", i-2), dout_o, VEC[i-2][15:0]);
      end
      if (i < NV) begin
        in_valid_i = 1'b1; sel_i = VEC[i][51:48]; acc_i = VEC[i][47:16];
      end else begin
        in_valid_i = 1'b0; acc_i = 32'h0000_7777;
      end
    end

    // R9: no valid -> output held
    last = dout_o;
    repeat (3) @(negedge clk_i);
    chk("R9 hold dout", dout_o, last);
    chk("R9 valid low", {15'd0, valid_o}, 16'h0000);

    // R8: single sample latency
    in_valid_i = 1'b1; sel_i = 4'd0; acc_i = 32'd7;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R8 not yet valid", {15'd0, valid_o}, 16'h0000);
    @(negedge clk_i);
    chk("R8 valid", {15'd0, valid_o}, 16'h0001);
    chk("R8 data", dout_o, 16'h0007);

    // R2: write takes effect; disabled write ignored
    wr(4'd6, 5'd1, 1'b0, 16'h7FFF, 16'h8000, 1'b1);
    wr(4'd6, 5'd2, 1'b0, 16'h7FFF, 16'h8000, 1'b0);
    in_valid_i = 1'b1; sel_i = 4'd6; acc_i = 32'd10;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R2 write then ignored write", dout_o, 16'h0005);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule